// File: doc/BRIEF.md
# Single-Slave 1-Wire Transaction Master

This block runs one complete transaction on a 1-Wire bus that carries exactly one slave. It is clocked at 1 MHz, so every count in the slot timing is one microsecond. A single-cycle start pulse latches a ROM command and a function command. The master then performs these steps in order:

1. It issues a reset pulse and looks for a presence answer.
2. It writes the ROM command.
3. If the ROM command asks for it, it reads the 64-bit ROM word.
4. It writes the function command.
5. It then does one of three things: reads a 72-bit data word, keeps polling with read slots until a conversion reports completion, or ends at once.

The bus is open-drain. The block never drives the line high. It has one enable, `pull_o`, that the pad turns into a pull to ground, and it reads the resolved line level back on `line_i`. An external pull-up returns the line high when no device pulls it down. `busy_o` covers the whole transaction. At the cycle it falls, either `done_o` or `fail_o` pulses for one cycle. `fail_o` means no device answered the reset.

Top module: `wire1_txn_master`

## Requirements
- R1: After reset, `pull_o`, `busy_o`, `done_o` and `fail_o` are low and both data words read zero.
- R2: The transaction opens with a reset slot. The line is pulled for 480 cycles and then released for 410 cycles. The line is sampled 70 cycles after release, and a low level there counts as presence. No single pull lasts longer than 480 cycles.
- R3: If the line is high at the presence sample, the transaction ends right after the reset slot: `fail_o` pulses, there is no `done_o` pulse and no further slot, and both data words keep their values.
- R4: Each slot lasts 70 cycles and is followed by exactly one released cycle before the next slot starts. Write slots send the ROM command and then the function command, bit 0 first. A 1 is sent as a 6-cycle pull, and a 0 as a 60-cycle pull.
- R5: ROM command 0x33 is followed by 64 read slots. Each read slot pulls for 6 cycles and samples the line 9 cycles after release. The first bit received ends in `rom_word_o[0]`. The word holds the family code in [7:0], the serial number in [55:8] and the check byte in [63:56].
- R6: Any other ROM command, 0xCC included, is followed directly by the function command write, with no read slots. `rom_word_o` is left unchanged.
- R7: Function command 0xBE is followed by 72 read slots, received first bit into bit 0. The word holds a signed 12-bit temperature in [11:0], the alarm bytes in [31:16], the configuration byte in [39:32] and the check byte in [71:64].
- R8: Function command 0x44 is followed by read slots that repeat until one returns 1. `done_o` follows that slot, and `fn_word_o` is left unchanged.
- R9: Any other function command ends the transaction with `done_o` right after its write, with no read slots.
- R10: `busy_o` rises the cycle after an accepted start and stays high until the last slot completes. In the cycle where `busy_o` falls, exactly one of `done_o` or `fail_o` is high, and it is high for that one cycle only.
- R11: A start pulse while `busy_o` is high is ignored, and the ongoing slot sequence is not disturbed.
- R12: `pull_o` is low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1 MHz clock, one cycle per microsecond |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle request to begin a transaction |
| rom_cmd_i | input | 8 | ROM command, latched at the accepted start |
| fn_cmd_i | input | 8 | Function command, latched at the accepted start |
| line_i | input | 1 | Resolved level of the bus line |
| pull_o | output | 1 | Open-drain enable: high pulls the line low, low releases it |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse: transaction completed with a device present |
| fail_o | output | 1 | One-cycle pulse: no presence answer, transaction aborted |
| rom_word_o | output | 64 | Collected ROM word |
| fn_word_o | output | 72 | Collected function data word |

## Verification
The bound checker watches, on every cycle, the rules that relate the handshake outputs to the line. Busy falls only together with exactly one single-cycle outcome pulse. The line is never pulled while idle or while a failure is reported. No pull runs longer than the reset pulse. A start during a transaction never ends it. Only the bench's scenarios can show the rest. Those are the exact slot durations and gaps, and the command-dependent choice of phases (read ROM versus any other ROM command; read, convert-and-poll or plain function commands). They also cover the bit order and field packing of the collected words, and the fact that words from phases that were skipped or aborted keep their old values. The bench checks these against a behavioural slave and a per-cycle expected line and handshake timeline.

// File: rtl/wire1_pkg.sv
package wire1_pkg;

  typedef enum logic [1:0] {
    SLOT_RST,
    SLOT_W0,
    SLOT_W1,
    SLOT_RD
  } slot_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RST,
    PH_WROM,
    PH_RROM,
    PH_WFN,
    PH_RFN,
    PH_POLL
  } phase_t;

  localparam logic [7:0] CMD_READ_ROM = 8'h33;
  localparam logic [7:0] CMD_CONVERT  = 8'h44;
  localparam logic [7:0] CMD_READ_PAD = 8'hBE;

endpackage

// File: rtl/wire1_slot_engine.sv
module wire1_slot_engine
  import wire1_pkg::*;
#(
  parameter int RST_LOW    = 480,
  parameter int RST_SAMPLE = 70,
  parameter int RST_HOLD   = 410,
  parameter int SLOT_LEN   = 70,
  parameter int W1_LOW     = 6,
  parameter int W0_LOW     = 60,
  parameter int RD_LOW     = 6,
  parameter int RD_WAIT    = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  slot_kind_t kind_i,
  input  logic       line_i,
  output logic       active_o,
  output logic       last_o,
  output logic       bit_o,
  output logic       pull_o
);

  localparam int CW = $clog2(RST_LOW + RST_HOLD);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_LOW + RST_HOLD - 1);
  localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_LEN - 1);
  localparam logic [CW-1:0] RST_AT    = CW'(RST_LOW + RST_SAMPLE);
  localparam logic [CW-1:0] RD_AT     = CW'(RD_LOW + RD_WAIT);

  logic            active_q, active_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  slot_kind_t      kind_q, kind_d;
  logic            bit_q, bit_d;
  logic            pull_q, pull_d;
  logic [CW-1:0]   last_at, samp_at;
  logic            last;

  function automatic logic [CW-1:0] low_of(slot_kind_t k);
    case (k)
      SLOT_RST: low_of = CW'(RST_LOW);
      SLOT_W0:  low_of = CW'(W0_LOW);
      SLOT_W1:  low_of = CW'(W1_LOW);
      default:  low_of = CW'(RD_LOW);
    endcase
  endfunction

  always_comb begin
    last_at = (kind_q == SLOT_RST) ? RST_LAST : SLOT_LAST;
    samp_at = (kind_q == SLOT_RST) ? RST_AT : RD_AT;
    last    = active_q && (cnt_q == last_at);
  end

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    kind_d   = kind_q;
    bit_d    = bit_q;
    if (!active_q) begin
      if (go_i) begin
        active_d = 1'b1;
        cnt_d    = '0;
        kind_d   = kind_i;
      end
    end else begin
      if (cnt_q == samp_at) bit_d = line_i;
      if (last) active_d = 1'b0;
      else      cnt_d = cnt_q + 1'b1;
    end
    pull_d = active_d && (cnt_d < low_of(kind_d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= SLOT_RST;
      bit_q    <= 1'b1;
      pull_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      kind_q   <= kind_d;
      bit_q    <= bit_d;
      pull_q   <= pull_d;
    end
  end

  assign active_o = active_q;
  assign last_o   = last;
  assign bit_o    = bit_q;
  assign pull_o   = pull_q;

endmodule

// File: rtl/wire1_collector.sv
module wire1_collector #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_i) word_d = {bit_i, word_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/wire1_txn_master.sv
module wire1_txn_master
  import wire1_pkg::*;
#(
  parameter int CMD_BITS   = 8,
  parameter int ROM_BITS   = 64,
  parameter int FN_BITS    = 72,
  parameter int RST_LOW    = 480,
  parameter int RST_SAMPLE = 70,
  parameter int RST_HOLD   = 410,
  parameter int SLOT_LEN   = 70,
  parameter int W1_LOW     = 6,
  parameter int W0_LOW     = 60,
  parameter int RD_LOW     = 6,
  parameter int RD_WAIT    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [7:0]          rom_cmd_i,
  input  logic [7:0]          fn_cmd_i,
  input  logic                line_i,
  output logic                pull_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic [ROM_BITS-1:0] rom_word_o,
  output logic [FN_BITS-1:0]  fn_word_o
);

  localparam int IW  = $clog2(FN_BITS > ROM_BITS ? FN_BITS : ROM_BITS);
  localparam int CIW = $clog2(CMD_BITS);
  localparam logic [IW-1:0] CMD_LAST = IW'(CMD_BITS - 1);
  localparam logic [IW-1:0] ROM_LAST = IW'(ROM_BITS - 1);
  localparam logic [IW-1:0] FN_LAST  = IW'(FN_BITS - 1);

  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  phase_t        phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [7:0]    romc_q, romc_d, fnc_q, fnc_d;
  logic          done_q, done_d, fail_q, fail_d;

  logic          eng_active, eng_last, eng_bit, slot_go, cmd_bit;
  slot_kind_t    kind;

  assign busy_o  = (phase_q != PH_IDLE);
  assign slot_go = busy_o && !eng_active;
  assign cmd_bit = (phase_q == PH_WROM) ? romc_q[idx_q[CIW-1:0]] : fnc_q[idx_q[CIW-1:0]];

  always_comb begin
    case (phase_q)
      PH_RST:         kind = SLOT_RST;
      PH_WROM, PH_WFN: kind = cmd_bit ? SLOT_W1 : SLOT_W0;
      default:        kind = SLOT_RD;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    romc_d  = romc_q;
    fnc_d   = fnc_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_d = PH_RST;
        romc_d  = rom_cmd_i;
        fnc_d   = fn_cmd_i;
        idx_d   = '0;
      end
    end else if (eng_last) begin
      idx_d = idx_q + 1'b1;
      case (phase_q)
        PH_RST: begin
          idx_d = '0;
          if (eng_bit) begin
            phase_d = PH_IDLE;
            fail_d  = 1'b1;
          end else begin
            phase_d = PH_WROM;
          end
        end
        PH_WROM: if (idx_q == CMD_LAST) begin
          idx_d   = '0;
          phase_d = (romc_q == CMD_READ_ROM) ? PH_RROM : PH_WFN;
        end
        PH_RROM: if (idx_q == ROM_LAST) begin
          idx_d   = '0;
          phase_d = PH_WFN;
        end
        PH_WFN: if (idx_q == CMD_LAST) begin
          idx_d = '0;
          if (fnc_q == CMD_READ_PAD)     phase_d = PH_RFN;
          else if (fnc_q == CMD_CONVERT) phase_d = PH_POLL;
          else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
        PH_RFN: if (idx_q == FN_LAST) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
        default: if (eng_bit) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      romc_q  <= '0;
      fnc_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      romc_q  <= romc_d;
      fnc_q   <= fnc_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  wire1_slot_engine #(
    .RST_LOW(RST_LOW), .RST_SAMPLE(RST_SAMPLE), .RST_HOLD(RST_HOLD),
    .SLOT_LEN(SLOT_LEN), .W1_LOW(W1_LOW), .W0_LOW(W0_LOW),
    .RD_LOW(RD_LOW), .RD_WAIT(RD_WAIT)
  ) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .go_i    (slot_go),
    .kind_i  (kind),
    .line_i  (line_i),
    .active_o(eng_active),
    .last_o  (eng_last),
    .bit_o   (eng_bit),
    .pull_o  (pull_o)
  );

  wire1_collector #(.W(ROM_BITS)) u_rom_word (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .shift_i(eng_last && (phase_q == PH_RROM)),
    .bit_i  (eng_bit),
    .word_o (rom_word_o)
  );

  wire1_collector #(.W(FN_BITS)) u_fn_word (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .shift_i(eng_last && (phase_q == PH_RFN)),
    .bit_i  (eng_bit),
    .word_o (fn_word_o)
  );

  assign done_o = done_q;
  assign fail_o = fail_q;

endmodule

// File: rtl/wire1_txn_checker.sv
module wire1_txn_checker #(
  parameter int RST_LOW = 480
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pull_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);

  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (!pull_o) run_q <= '0;
    else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
  end

  a_r2_low_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(run_q) <= RST_LOW);

  a_r3_fail_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !pull_o);

  a_r10_fall_has_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o ^ fail_o));

  a_r10_outcome_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> $fell(busy_o));

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |=> !(done_o || fail_o));

  a_r11_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o || fail_o));

  a_r12_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !pull_o);

endmodule

bind wire1_txn_master wire1_txn_checker #(.RST_LOW(RST_LOW)) u_wire1_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .pull_o (pull_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .fail_o (fail_o)
);

// File: tb/test_wire1_txn_master.sv
module test_wire1_txn_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  rom_cmd, fn_cmd;
  logic        line, pull, busy, done, fail;
  logic [63:0] rom_word;
  logic [71:0] fn_word;
  logic        slave_low;

  always #5 clk = ~clk;
  assign line = !(pull || slave_low);

  wire1_txn_master i_wire1_txn_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rom_cmd_i(rom_cmd), .fn_cmd_i(fn_cmd), .line_i(line),
    .pull_o(pull), .busy_o(busy), .done_o(done), .fail_o(fail),
    .rom_word_o(rom_word), .fn_word_o(fn_word)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input string tag, input bit ok, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- expected timeline: {pull, busy, done, fail} per cycle
  logic [3:0] exp_q[$];
  int         tl_err, tl_cyc;
  logic [3:0] tl_act, tl_exp;
  bit         tl_on = 0;

  task automatic push(input int n, input logic [3:0] v);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  task automatic push_slot(input int low);
    push(1, 4'b0100);
    push(low, 4'b1100);
    push(70 - low, 4'b0100);
  endtask

  task automatic build_expect(input logic [7:0] rc, input logic [7:0] fc, input bit present, input int polls);
    push(1, 4'b0100);
    push(480, 4'b1100);
    push(410, 4'b0100);
    if (!present) begin
      push(1, 4'b0001);
      return;
    end
    for (int i = 0; i < 8; i++) push_slot(rc[i] ? 6 : 60);
    if (rc == 8'h33) for (int i = 0; i < 64; i++) push_slot(6);
    for (int i = 0; i < 8; i++) push_slot(fc[i] ? 6 : 60);
    if (fc == 8'hBE) for (int i = 0; i < 72; i++) push_slot(6);
    else if (fc == 8'h44) for (int i = 0; i <= polls; i++) push_slot(6);
    push(1, 4'b0010);
  endtask

  always @(negedge clk) begin
    if (tl_on) begin
      logic [3:0] e, a;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b0000;
      a = {pull, busy, done, fail};
      if (a !== e) begin
        if (tl_err == 0) begin
          tl_act = a;
          tl_exp = e;
          tl_cyc = checks;
        end
        tl_err++;
      end
    end
  end

  // ---------------- behavioural slave
  localparam int SP_IDLE = 0, SP_RCMD = 1, SP_RROM = 2, SP_FCMD = 3, SP_RFN = 4, SP_CONV = 5;
  int          sph, sidx, slv_polls, n;
  bit          slv_present, rd, drv0, wbit;
  logic [7:0]  rx, rx_rom, rx_fn;
  logic [63:0] slv_rom;
  logic [71:0] slv_fn;

  task automatic slave_advance(input bit b);
    case (sph)
      SP_RCMD: begin
        rx[sidx] = b; sidx++;
        if (sidx == 8) begin rx_rom = rx; sidx = 0; sph = (rx == 8'h33) ? SP_RROM : SP_FCMD; end
      end
      SP_RROM: begin sidx++; if (sidx == 64) begin sidx = 0; sph = SP_FCMD; end end
      SP_FCMD: begin
        rx[sidx] = b; sidx++;
        if (sidx == 8) begin
          rx_fn = rx; sidx = 0;
          sph = (rx == 8'hBE) ? SP_RFN : (rx == 8'h44) ? SP_CONV : SP_IDLE;
        end
      end
      SP_RFN: begin sidx++; if (sidx == 72) begin sidx = 0; sph = SP_IDLE; end end
      SP_CONV: sidx++;
      default: ;
    endcase
  endtask

  initial begin
    slave_low = 1'b0; sph = SP_IDLE; sidx = 0;
    forever begin
      @(negedge clk);
      if (pull) begin
        n = 1;
        rd = (sph == SP_RROM) || (sph == SP_RFN) || (sph == SP_CONV);
        drv0 = 1'b0;
        if (sph == SP_RROM)      drv0 = !slv_rom[sidx];
        else if (sph == SP_RFN)  drv0 = !slv_fn[sidx];
        else if (sph == SP_CONV) drv0 = (sidx < slv_polls);
        slave_low = drv0;
        wbit = 1'b0;
        while (pull || n < 30) begin
          @(negedge clk);
          n++;
          if (n == 30) begin wbit = line; slave_low = 1'b0; end
        end
        if (n > 100) begin
          repeat (20) @(negedge clk);
          if (slv_present) begin
            slave_low = 1'b1;
            repeat (100) @(negedge clk);
            slave_low = 1'b0;
          end
          sph = SP_RCMD; sidx = 0;
        end else if (!rd) slave_advance(wbit);
        else slave_advance(1'b0);
      end
    end
  end

  // ---------------- transaction driver
  task automatic run_tx(input logic [7:0] rc, input logic [7:0] fc, input bit present, input int polls, input string tag);
    slv_present = present;
    slv_polls   = polls;
    tl_err      = 0;
    rx_rom      = 8'hxx;
    rx_fn       = 8'hxx;
    @(negedge clk);
    start = 1'b1; rom_cmd = rc; fn_cmd = fc;
    @(posedge clk);
    #1;
    start = 1'b0; rom_cmd = ~rc; fn_cmd = ~fc;
    build_expect(rc, fc, present, polls);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " timeline"}, tl_err == 0, {68'd0, tl_act}, {68'd0, tl_exp});
  endtask

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [63:0] keep_rom;
  logic [71:0] keep_fn;

  initial begin
    start = 1'b0; rom_cmd = 8'h00; fn_cmd = 8'h00; rst_n = 1'b0;
    slv_present = 1'b1; slv_polls = 0;
    slv_rom = 64'h0; slv_fn = 72'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 handshake idle", {pull, busy, done, fail} == 4'b0, {68'd0, pull, busy, done, fail}, 72'd0);
    check("R1 rom word zero", rom_word == 64'd0, {8'd0, rom_word}, 72'd0);
    check("R1 fn word zero", fn_word == 72'd0, fn_word, 72'd0);
    tl_on = 1;

    // R2 R4 R5 R7: read ROM then read scratch data
    slv_rom = {8'hA7, 48'h0004_5C91_E2B3, 8'h3B};
    slv_fn  = {8'h5D, 24'hFFFF0C, 8'h7F, 16'h4B46, 4'h0, 12'hFE7};
    run_tx(8'h33, 8'hBE, 1'b1, 0, "R2 R4 R5 R7 R10");
    check("R4 rom command bits", rx_rom == 8'h33, {64'd0, rx_rom}, 72'h33);
    check("R4 fn command bits", rx_fn == 8'hBE, {64'd0, rx_fn}, 72'hBE);
    check("R5 rom word", rom_word == slv_rom, {8'd0, rom_word}, {8'd0, slv_rom});
    check("R5 family field", rom_word[7:0] == 8'h3B, {64'd0, rom_word[7:0]}, 72'h3B);
    check("R5 serial field", rom_word[55:8] == 48'h0004_5C91_E2B3, {24'd0, rom_word[55:8]}, 72'h00045C91E2B3);
    check("R5 check field", rom_word[63:56] == 8'hA7, {64'd0, rom_word[63:56]}, 72'hA7);
    check("R7 fn word", fn_word == slv_fn, fn_word, slv_fn);
    check("R7 temperature signed", $signed(fn_word[11:0]) == -25, {60'd0, fn_word[11:0]}, 72'hFE7);
    check("R7 alarm field", fn_word[31:16] == 16'h4B46, {56'd0, fn_word[31:16]}, 72'h4B46);
    check("R7 config field", fn_word[39:32] == 8'h7F, {64'd0, fn_word[39:32]}, 72'h7F);
    check("R7 check field", fn_word[71:64] == 8'h5D, {64'd0, fn_word[71:64]}, 72'h5D);

    // R6 skip ROM, new scratch data
    keep_rom = rom_word;
    slv_rom  = 64'h1111_2222_3333_4444;
    slv_fn   = {8'h91, 24'h00A5A5, 8'h1F, 16'h0102, 4'h0, 12'h190};
    run_tx(8'hCC, 8'hBE, 1'b1, 0, "R6 R7");
    check("R6 rom word unchanged", rom_word == keep_rom, {8'd0, rom_word}, {8'd0, keep_rom});
    check("R7 second fn word", fn_word == slv_fn, fn_word, slv_fn);
    check("R4 skip command bits", rx_rom == 8'hCC, {64'd0, rx_rom}, 72'hCC);

    // R8 convert with three busy polls
    keep_fn = fn_word;
    run_tx(8'hCC, 8'h44, 1'b1, 3, "R8");
    check("R8 fn word unchanged", fn_word == keep_fn, fn_word, keep_fn);
    check("R8 convert command bits", rx_fn == 8'h44, {64'd0, rx_fn}, 72'h44);

    // R3 no presence
    keep_rom = rom_word;
    keep_fn  = fn_word;
    run_tx(8'h33, 8'hBE, 1'b0, 0, "R3");
    check("R3 rom word unchanged", rom_word == keep_rom, {8'd0, rom_word}, {8'd0, keep_rom});
    check("R3 fn word unchanged", fn_word == keep_fn, fn_word, keep_fn);

    // R6 R9 other commands
    run_tx(8'h55, 8'h48, 1'b1, 0, "R6 R9");
    check("R9 fn word unchanged", fn_word == keep_fn, fn_word, keep_fn);
    check("R6 other rom cmd keeps word", rom_word == keep_rom, {8'd0, rom_word}, {8'd0, keep_rom});

    // R11 start during transaction, read ROM and convert with no busy polls
    slv_rom = 64'hFEDC_BA98_7654_3210;
    fork
      run_tx(8'h33, 8'h44, 1'b1, 0, "R11 R8");
      begin
        repeat (2000) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    check("R11 rom word after ignored start", rom_word == slv_rom, {8'd0, rom_word}, {8'd0, slv_rom});
    check("R12 idle after run", {pull, busy} == 2'b00, {70'd0, pull, busy}, 72'd0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule